// File: doc/BRIEF.md
# Nibble-Configurable Multiplexed I/O Port

This block controls an 8-bit bidirectional pad group for a small microcontroller. The pins are split into two 4-bit halves, and a mode register sets each half on its own. A half can be a general input, a general output, or a driver for part of the high-order external memory address. In address mode the lower half carries address bits 11..8 and the upper half carries bits 15..12. A program that needs 12 address bits or fewer can therefore keep the upper half free for ordinary I/O.

A boot strap selects the reset configuration. With external program memory, both halves come up as address drivers and a slow-bus timing flag is raised. With internal program memory, both halves come up as inputs. A global option makes every general output open-drain. A bus-float request releases every address pin.

An optional two-wire strobe handshake moves data through the port. The handshake uses an active-low data-valid line and a ready line, and its direction follows the upper half's direction. On output, a CPU write starts a transfer, and a flag that software can read reports completion. On input, the data-valid strobe captures the pins, and ready is held low until the CPU reads the captured byte.

Top module: `nib_port`

## Requirements
- R1: The MODE register (reg_sel 1) holds a 2-bit code per half: bits 1:0 set the lower half and bits 3:2 the upper half. The codes are 00 input, 01 output, 10 address and 11 reserved (behaves as input). An output half drives pad_oe high and pad_out from the data latch, which is written at reg_sel 0. An input half leaves pad_oe low and pad_out equal to the latch.
- R2: An address half drives pad_oe high. The lower half outputs addr_hi[3:0] (address bits 11..8) and the upper half outputs addr_hi[7:4] (address bits 15..12).
- R3: The two halves are independent. Any mix of input, output and address codes behaves per half as R1 and R2 describe.
- R4: Reset with boot_ext=1 sets both halves to address mode (MODE reads 0x0A) and sets ext_timing to 1.
- R5: Reset with boot_ext=0 sets both halves to input (MODE reads 0x00), makes pad_oe 0x00 and sets ext_timing to 0.
- R6: Writing the CTRL register (reg_sel 2) sets ext_timing to wr_data bit 0, so software can clear it. Reading CTRL returns ext_timing in bit 0 and the handshake done flag in bit 1.
- R7: While bus_float=1, every pin of an address-mode half has pad_oe=0. Output and input halves are not affected.
- R8: MODE bit 4 selects open-drain. Each output-mode pin then has pad_od=1 and drives pad_oe only when its latch bit is 0. Address pins stay push-pull.
- R9: MODE bit 5 enables the handshake. A MODE write that sets bit 5 is rejected, and the register keeps its old value, unless both halves carry the same code and that code is 00 or 01.
- R10: In output handshake (upper half = 01), hs_dav_oe=1. A DATA write drives hs_dav_n_o low and clears done. The first clock edge that samples hs_rdy_i=0 returns hs_dav_n_o high and sets done.
- R11: In input handshake (upper half = 00), hs_rdy_oe=1. The first clock edge that samples hs_dav_n_i=0 captures pad_in and drives hs_rdy_o low. hs_rdy_o stays low until a DATA read, and DATA reads return the captured byte.
- R12: After that read, no new capture happens until the block has seen hs_dav_n_i=1.
- R13: Outside the input handshake, a DATA read returns, per half, the latch for an output half, and otherwise pad_in as registered one clock earlier. rd_data is zero while rd_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_ext | input | 1 | Strap: 1 = external program memory |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | 0 DATA, 1 MODE, 2 CTRL |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational) |
| addr_hi | input | 8 | Address bits 15..8 from the bus unit |
| bus_float | input | 1 | Request to float the address pins |
| pad_in | input | 8 | Pin input levels |
| pad_out | output | 8 | Pin output data |
| pad_oe | output | 8 | Pin output enable |
| pad_od | output | 8 | Pin open-drain select |
| ext_timing | output | 1 | Slow external bus timing flag |
| hs_dav_n_i | input | 1 | Data-valid strobe in (active low) |
| hs_dav_n_o | output | 1 | Data-valid strobe out (active low) |
| hs_dav_oe | output | 1 | Data-valid driver enable |
| hs_rdy_i | input | 1 | Ready line in |
| hs_rdy_o | output | 1 | Ready line out |
| hs_rdy_oe | output | 1 | Ready driver enable |

## Verification
The bench targets five kinds of error:
- Mixed configurations with one address half and one I/O half. A design that decoded the halves together would drive the wrong address nibble or enable the wrong half.
- The bus-float request, applied both to full address mode and to a mixed mode. A design that applied it too widely would release general outputs.
- The boot strap, checked in both values. A design that ignored it would come up driving pins that should float.
- Handshake configurations with mismatched or address codes. These must leave MODE unchanged; a lenient design would accept them.
- A data-valid strobe held low after the CPU read. A design that re-armed at once would overwrite the captured byte with a second capture.

// File: rtl/nib_port_pkg.sv
package nib_port_pkg;

    typedef enum logic [1:0] {
        NM_IN   = 2'b00,
        NM_OUT  = 2'b01,
        NM_ADDR = 2'b10,
        NM_RSV  = 2'b11
    } nib_mode_e;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_MODE = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_OUT_WAIT,
        HS_IN_HELD,
        HS_IN_REL
    } hs_state_e;

endpackage

// File: rtl/nib_port_cfg.sv
module nib_port_cfg
    import nib_port_pkg::*;
#(
    parameter int NIB_W   = 4,
    parameter int NUM_NIB = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            boot_ext,
    input  logic                            wr_en,
    input  logic [1:0]                      reg_sel,
    input  logic [NIB_W*NUM_NIB-1:0]        wr_data,
    output logic [NUM_NIB-1:0][1:0]         mode_o,
    output logic                            od_o,
    output logic                            hs_en_o,
    output logic                            ext_o,
    output logic [NIB_W*NUM_NIB-1:0]        latch_o
);
    localparam int W      = NIB_W * NUM_NIB;
    localparam int MF_W   = 2 * NUM_NIB;
    localparam int OD_BIT = MF_W;
    localparam int HS_BIT = MF_W + 1;

    typedef struct packed {
        logic [NUM_NIB-1:0][1:0] mode;
        logic                    od;
        logic                    hs;
        logic                    ext;
        logic [W-1:0]            latch;
    } cfg_t;

    cfg_t cfg_d, cfg_q, cfg_rst;
    logic mode_ok;
    logic [NUM_NIB-1:0][1:0] new_mode;

    always_comb begin
        new_mode = wr_data[MF_W-1:0];
        mode_ok  = 1'b1;
        if (wr_data[HS_BIT]) begin
            if (new_mode[NUM_NIB-1][1]) mode_ok = 1'b0;
            for (int i = 0; i < NUM_NIB; i++) begin
                if (new_mode[i] != new_mode[NUM_NIB-1]) mode_ok = 1'b0;
            end
        end
    end

    always_comb begin
        cfg_rst       = '0;
        cfg_rst.ext   = boot_ext;
        for (int i = 0; i < NUM_NIB; i++) begin
            cfg_rst.mode[i] = boot_ext ? NM_ADDR : NM_IN;
        end

        cfg_d = cfg_q;
        if (wr_en) begin
            case (reg_sel)
                SEL_DATA: cfg_d.latch = wr_data;
                SEL_MODE: begin
                    if (mode_ok) begin
                        cfg_d.mode = new_mode;
                        cfg_d.od   = wr_data[OD_BIT];
                        cfg_d.hs   = wr_data[HS_BIT];
                    end
                end
                SEL_CTRL: cfg_d.ext = wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_rst;
        else        cfg_q <= cfg_d;
    end

    assign mode_o  = cfg_q.mode;
    assign od_o    = cfg_q.od;
    assign hs_en_o = cfg_q.hs;
    assign ext_o   = cfg_q.ext;
    assign latch_o = cfg_q.latch;

    logic modes_same;
    always_comb begin
        modes_same = !cfg_q.mode[NUM_NIB-1][1];
        for (int i = 0; i < NUM_NIB; i++) begin
            if (cfg_q.mode[i] != cfg_q.mode[NUM_NIB-1]) modes_same = 1'b0;
        end
    end

    AST_HS_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.hs |-> modes_same); // R9

    AST_EXT_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_q.ext) |-> $past(wr_en && reg_sel == SEL_CTRL)); // R6

endmodule

// File: rtl/nib_port_hs.sv
module nib_port_hs
    import nib_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hs_en,
    input  logic         dir_out,
    input  logic         data_wr,
    input  logic         data_rd,
    input  logic         dav_n_i,
    input  logic         rdy_i,
    input  logic [W-1:0] pad_in,
    output logic         dav_n_o,
    output logic         rdy_o,
    output logic         done_o,
    output logic [W-1:0] cap_o
);
    typedef struct packed {
        hs_state_e    st;
        logic         done;
        logic [W-1:0] cap;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d = hs_q;
        if (!hs_en) begin
            hs_d.st = HS_IDLE;
        end else begin
            case (hs_q.st)
                HS_IDLE: begin
                    if (dir_out) begin
                        if (data_wr) begin
                            hs_d.st   = HS_OUT_WAIT;
                            hs_d.done = 1'b0;
                        end
                    end else if (!dav_n_i) begin
                        hs_d.cap = pad_in;
                        hs_d.st  = HS_IN_HELD;
                    end
                end
                HS_OUT_WAIT: begin
                    if (!rdy_i) begin
                        hs_d.st   = HS_IDLE;
                        hs_d.done = 1'b1;
                    end else if (data_wr) begin
                        hs_d.done = 1'b0;
                    end
                end
                HS_IN_HELD: if (data_rd) hs_d.st = HS_IN_REL;
                HS_IN_REL:  if (dav_n_i) hs_d.st = HS_IDLE;
                default:    hs_d.st = HS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= '{st: HS_IDLE, done: 1'b0, cap: '0};
        else        hs_q <= hs_d;
    end

    assign dav_n_o = (hs_q.st != HS_OUT_WAIT);
    assign rdy_o   = (hs_q.st != HS_IN_HELD);
    assign done_o  = hs_q.done;
    assign cap_o   = hs_q.cap;

    AST_DAV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dav_n_o && hs_en && !rdy_i) |=> (dav_n_o && done_o)); // R10

    AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_o && hs_en && !data_rd) |=> !rdy_o); // R11

    AST_NO_RECAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_q.st == HS_IN_REL && !dav_n_i) |=> $stable(cap_o)); // R12

endmodule

// File: rtl/nib_port_pad.sv
module nib_port_pad
    import nib_port_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic [1:0]       mode,
    input  logic             od_en,
    input  logic             flt,
    input  logic [NIB_W-1:0] latch,
    input  logic [NIB_W-1:0] addr,
    output logic [NIB_W-1:0] out,
    output logic [NIB_W-1:0] oe,
    output logic [NIB_W-1:0] od
);
    always_comb begin
        out = latch;
        oe  = '0;
        od  = '0;
        case (mode)
            NM_OUT: begin
                oe = od_en ? ~latch : '1;
                od = {NIB_W{od_en}};
            end
            NM_ADDR: begin
                out = addr;
                oe  = flt ? '0 : '1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nib_port.sv
module nib_port
    import nib_port_pkg::*;
#(
    parameter int NIB_W   = 4,
    parameter int NUM_NIB = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     boot_ext,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [1:0]               reg_sel,
    input  logic [NIB_W*NUM_NIB-1:0] wr_data,
    output logic [NIB_W*NUM_NIB-1:0] rd_data,
    input  logic [NIB_W*NUM_NIB-1:0] addr_hi,
    input  logic                     bus_float,
    input  logic [NIB_W*NUM_NIB-1:0] pad_in,
    output logic [NIB_W*NUM_NIB-1:0] pad_out,
    output logic [NIB_W*NUM_NIB-1:0] pad_oe,
    output logic [NIB_W*NUM_NIB-1:0] pad_od,
    output logic                     ext_timing,
    input  logic                     hs_dav_n_i,
    output logic                     hs_dav_n_o,
    output logic                     hs_dav_oe,
    input  logic                     hs_rdy_i,
    output logic                     hs_rdy_o,
    output logic                     hs_rdy_oe
);
    localparam int W      = NIB_W * NUM_NIB;
    localparam int MF_W   = 2 * NUM_NIB;
    localparam int OD_BIT = MF_W;
    localparam int HS_BIT = MF_W + 1;

    logic [NUM_NIB-1:0][1:0] mode;
    logic                    od_en, hs_en, done, dir_out;
    logic [W-1:0]            latch, cap;
    logic                    data_wr, data_rd;

    typedef struct packed {
        logic [W-1:0] pins;
    } smp_t;

    smp_t smp_d, smp_q;

    assign data_wr = wr_en && (reg_sel == SEL_DATA);
    assign data_rd = rd_en && (reg_sel == SEL_DATA);
    assign dir_out = (mode[NUM_NIB-1] == NM_OUT);

    nib_port_cfg #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_ext (boot_ext),
        .wr_en    (wr_en),
        .reg_sel  (reg_sel),
        .wr_data  (wr_data),
        .mode_o   (mode),
        .od_o     (od_en),
        .hs_en_o  (hs_en),
        .ext_o    (ext_timing),
        .latch_o  (latch)
    );

    nib_port_hs #(.W(W)) u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_en    (hs_en),
        .dir_out  (dir_out),
        .data_wr  (data_wr),
        .data_rd  (data_rd),
        .dav_n_i  (hs_dav_n_i),
        .rdy_i    (hs_rdy_i),
        .pad_in   (pad_in),
        .dav_n_o  (hs_dav_n_o),
        .rdy_o    (hs_rdy_o),
        .done_o   (done),
        .cap_o    (cap)
    );

    assign hs_dav_oe = hs_en && dir_out;
    assign hs_rdy_oe = hs_en && !dir_out;

    for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
        nib_port_pad #(.NIB_W(NIB_W)) u_pad (
            .mode  (mode[g]),
            .od_en (od_en),
            .flt   (bus_float),
            .latch (latch[g*NIB_W +: NIB_W]),
            .addr  (addr_hi[g*NIB_W +: NIB_W]),
            .out   (pad_out[g*NIB_W +: NIB_W]),
            .oe    (pad_oe[g*NIB_W +: NIB_W]),
            .od    (pad_od[g*NIB_W +: NIB_W])
        );

        AST_FLOAT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_float && mode[g] == NM_ADDR) |-> (pad_oe[g*NIB_W +: NIB_W] == '0)); // R7

        AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (od_en && mode[g] == NM_OUT) |->
            ((pad_oe[g*NIB_W +: NIB_W] & pad_out[g*NIB_W +: NIB_W]) == '0)); // R8
    end

    always_comb begin
        smp_d.pins = pad_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (reg_sel)
                SEL_DATA: begin
                    for (int i = 0; i < NUM_NIB; i++) begin
                        if (mode[i] == NM_OUT)
                            rd_data[i*NIB_W +: NIB_W] = latch[i*NIB_W +: NIB_W];
                        else if (hs_en)
                            rd_data[i*NIB_W +: NIB_W] = cap[i*NIB_W +: NIB_W];
                        else
                            rd_data[i*NIB_W +: NIB_W] = smp_q.pins[i*NIB_W +: NIB_W];
                    end
                end
                SEL_MODE: begin
                    rd_data[MF_W-1:0] = mode;
                    rd_data[OD_BIT]   = od_en;
                    rd_data[HS_BIT]   = hs_en;
                end
                SEL_CTRL: begin
                    rd_data[0] = ext_timing;
                    rd_data[1] = done;
                end
                default: ;
            endcase
        end
    end

    AST_ADDR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[0] == NM_ADDR) |-> (pad_out[NIB_W-1:0] == addr_hi[NIB_W-1:0])); // R2

endmodule

// File: tb/nib_port_tb.sv
module nib_port_tb;
    logic       clk = 1'b0;
    logic       rst_n, boot_ext, wr_en, rd_en, bus_float;
    logic [1:0] reg_sel;
    logic [7:0] wr_data, rd_data, addr_hi, pad_in, pad_out, pad_oe, pad_od;
    logic       ext_timing, hs_dav_n_i, hs_dav_n_o, hs_dav_oe;
    logic       hs_rdy_i, hs_rdy_o, hs_rdy_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    nib_port u_dut (
        .clk(clk), .rst_n(rst_n), .boot_ext(boot_ext), .wr_en(wr_en),
        .rd_en(rd_en), .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
        .addr_hi(addr_hi), .bus_float(bus_float), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
        .ext_timing(ext_timing), .hs_dav_n_i(hs_dav_n_i), .hs_dav_n_o(hs_dav_n_o),
        .hs_dav_oe(hs_dav_oe), .hs_rdy_i(hs_rdy_i), .hs_rdy_o(hs_rdy_o),
        .hs_rdy_oe(hs_rdy_oe)
    );

    typedef struct packed {
        logic [7:0] mode;
        logic [7:0] data;
        logic [7:0] addr;
        logic       flt;
        logic [7:0] pin;
        logic [7:0] e_out;
        logic [7:0] e_oe;
        logic [7:0] e_od;
        logic [7:0] e_rd;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{8'h05, 8'hA5, 8'h3C, 1'b0, 8'h11, 8'hA5, 8'hFF, 8'h00, 8'hA5},
        '{8'h15, 8'hA5, 8'h3C, 1'b0, 8'h11, 8'hA5, 8'h5A, 8'hFF, 8'hA5},
        '{8'h0A, 8'hA5, 8'h3C, 1'b0, 8'h66, 8'h3C, 8'hFF, 8'h00, 8'h66},
        '{8'h0A, 8'hA5, 8'h3C, 1'b1, 8'h66, 8'h3C, 8'h00, 8'h00, 8'h66},
        '{8'h06, 8'h90, 8'h7E, 1'b1, 8'h23, 8'h9E, 8'hF0, 8'h00, 8'h93},
        '{8'h12, 8'h50, 8'h7E, 1'b0, 8'hC4, 8'h5E, 8'h0F, 8'h00, 8'hC4},
        '{8'h00, 8'h81, 8'h00, 1'b0, 8'h3B, 8'h81, 8'h00, 8'h00, 8'h3B},
        '{8'h09, 8'h4D, 8'hB2, 1'b0, 8'h77, 8'hBD, 8'hFF, 8'h00, 8'h7D},
        '{8'h19, 8'h4D, 8'hB2, 1'b0, 8'h77, 8'hBD, 8'hF2, 8'h0F, 8'h7D}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] v);
        rd_en = 1'b1; reg_sel = sel;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst_n = 0; boot_ext = 1; wr_en = 0; rd_en = 0; reg_sel = 0; wr_data = 0;
        addr_hi = 8'hC3; bus_float = 0; pad_in = 0; hs_dav_n_i = 1; hs_rdy_i = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R4 oe", pad_oe, 8'hFF);
        check("R4 addr out", pad_out, 8'hC3);
        check("R4 ext", {7'd0, ext_timing}, 8'h01);
        rd(2'd1, v); check("R4 mode", v, 8'h0A);
        wr(2'd2, 8'h00);
        check("R6 ext clear", {7'd0, ext_timing}, 8'h00);
        rd(2'd2, v); check("R6 ctrl read", v, 8'h00);

        for (int i = 0; i < 9; i++) begin
            wr(2'd1, VECS[i].mode);
            wr(2'd0, VECS[i].data);
            addr_hi = VECS[i].addr; bus_float = VECS[i].flt; pad_in = VECS[i].pin;
            repeat (2) @(negedge clk);
            check("R1/R2/R3/R7 pad_out", pad_out, VECS[i].e_out);
            check("R1/R3/R7/R8 pad_oe", pad_oe, VECS[i].e_oe);
            check("R8 pad_od", pad_od, VECS[i].e_od);
            rd(2'd0, v); check("R13 data read", v, VECS[i].e_rd);
        end
        bus_float = 0;

        wr(2'd1, 8'h24);
        rd(2'd1, v); check("R9 reject mismatch", v, 8'h19);
        wr(2'd1, 8'h2A);
        rd(2'd1, v); check("R9 reject addr hs", v, 8'h19);
        check("R9 no dav drive", {7'd0, hs_dav_oe}, 8'h00);

        rst_n = 0; boot_ext = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R5 oe", pad_oe, 8'h00);
        check("R5 ext", {7'd0, ext_timing}, 8'h00);
        rd(2'd1, v); check("R5 mode", v, 8'h00);
        rd(2'd0, 8'h00 == 8'h00 ? v : v); rd_en = 0;
        rd_en = 0; #1 check("R13 idle read zero", rd_data, 8'h00);

        wr(2'd1, 8'h25);
        rd(2'd1, v); check("R9 accept hs out", v, 8'h25);
        check("R10 dav oe", {6'd0, hs_dav_oe, hs_rdy_oe}, 8'h02);
        wr(2'd0, 8'h3C);
        check("R10 dav low", {7'd0, hs_dav_n_o}, 8'h00);
        check("R10 data", pad_out, 8'h3C);
        rd(2'd2, v); check("R10 done clear", v, 8'h00);
        repeat (3) @(negedge clk);
        check("R10 dav held", {7'd0, hs_dav_n_o}, 8'h00);
        hs_rdy_i = 0;
        @(negedge clk);
        check("R10 dav release", {7'd0, hs_dav_n_o}, 8'h01);
        rd(2'd2, v); check("R10 done set", v, 8'h02);
        hs_rdy_i = 1;

        wr(2'd1, 8'h20);
        check("R11 rdy oe", {6'd0, hs_dav_oe, hs_rdy_oe}, 8'h01);
        check("R11 rdy idle", {7'd0, hs_rdy_o}, 8'h01);
        pad_in = 8'h5A; hs_dav_n_i = 0;
        @(negedge clk);
        check("R11 rdy low", {7'd0, hs_rdy_o}, 8'h00);
        pad_in = 8'hFF;
        repeat (2) @(negedge clk);
        check("R11 rdy held", {7'd0, hs_rdy_o}, 8'h00);
        rd(2'd0, v); check("R11 captured", v, 8'h5A);
        check("R11 rdy release", {7'd0, hs_rdy_o}, 8'h01);
        repeat (2) @(negedge clk);
        check("R12 no rearm", {7'd0, hs_rdy_o}, 8'h01);
        rd(2'd0, v); check("R12 capture kept", v, 8'h5A);
        hs_dav_n_i = 1;
        @(negedge clk);
        pad_in = 8'h33; hs_dav_n_i = 0;
        @(negedge clk);
        check("R12 rearm rdy", {7'd0, hs_rdy_o}, 8'h00);
        rd(2'd0, v); check("R12 new capture", v, 8'h33);
        hs_dav_n_i = 1;

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule